// File: doc/BRIEF.md
# Parallel 8080-Style Display Bus Master

This block is the host side of an 8-bit 8080-style parallel link to a small display controller. It takes requests on a simple valid/ready port and turns each one into bus cycles with chip select, write strobe, read strobe and a command/data select line. A request can be a command byte, a data or parameter byte, a whole pixel, a single-byte register read, or an end-of-burst marker.

Pixels are split into bus bytes according to a runtime format selector. RGB565 takes two write strobes. RGB666 and RGB888 each take three. The setup time before a strobe falls, the strobe low time and the strobe high time are runtime values counted in system clocks. Chip select stays low while requests keep arriving. It is released after one strobe period of idle time, or at once when an end-of-burst request arrives.

Request kinds on `req_kind`: 0 command byte, 1 data byte, 2 pixel, 3 read, and 4 to 7 end of burst. Pixel format codes on `pix_fmt`: 0 RGB565, 1 RGB666, and 2 or 3 RGB888.

Top module: `pbus_display_master`

## Requirements
- R1: After reset, chip select, write strobe and read strobe are high, the data-valid pulse is low, the data drivers are enabled and `req_ready` is high.
- R2: Chip select is low in every cycle in which either strobe is low, and in the cycle before a strobe falls. The two strobes are never low at the same time.
- R3: For a write, the byte and the command/data level are on the bus at least the setup time before the write strobe falls. They stay unchanged until the strobe rises.
- R4: A command byte (kind 0) goes out with command/data low. Data bytes (kind 1) and every pixel byte (kind 2) go out with it high.
- R5: The strobe stays low for exactly the low-time value. Between two strobes of the same request it stays high for the high time plus one cycle plus the setup time. A timing value of 0 behaves as 1.
- R6: An RGB565 pixel (format 0) is taken from bits 15:0 of the word and sent as bits 15:8 first, then bits 7:0.
- R7: An RGB666 pixel (format 1) carries red in bits 17:12, green in 11:6 and blue in 5:0. It is sent as three bytes in red, green, blue order, each with the 6 bits in bits 7:2 and zeros in bits 1:0.
- R8: An RGB888 pixel (format 2 or 3) is sent as bits 23:16, then 15:8, then 7:0.
- R9: A read (kind 3) disables the data drivers, holds command/data high and holds the read strobe low for the low-time value. It captures the data lines at the rising edge of the read strobe. `rd_valid` pulses for exactly that one cycle, with the captured byte on `rd_data`.
- R10: `req_ready` falls the cycle after a byte request is accepted. It stays low until the last strobe of that request has finished its high phase. No strobe is low while it is high.
- R11: Back-to-back requests keep chip select low. After the block goes idle, chip select rises once setup plus low plus high time (clamped values) cycles have passed with no new request.
- R12: An end-of-burst request (kind 4 to 7) raises chip select the cycle after it is accepted, without any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 3 | Request kind: 0 command, 1 data, 2 pixel, 3 read, 4-7 end of burst |
| req_word | input | 24 | Byte in bits 7:0, or a whole pixel |
| pix_fmt | input | 2 | Pixel format: 0 RGB565, 1 RGB666, 2/3 RGB888 |
| cfg_setup | input | 8 | Data setup before the strobe falls, in clocks |
| cfg_low | input | 8 | Strobe low time, in clocks |
| cfg_high | input | 8 | Strobe high time, in clocks |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_dc | output | 1 | Command (low) / data (high) select |
| bus_d_out | output | 8 | Data lines driven by the block |
| bus_d_oe | output | 1 | Data line driver enable |
| bus_d_in | input | 8 | Data lines as seen from the display |
| rd_valid | output | 1 | Read byte valid, one-cycle pulse |
| rd_data | output | 8 | Byte captured by a read |

## Verification
A request is accepted at a clock edge, and `req_ready` is low from the next edge on. Chip select, data and command/data change one edge later still. The strobe falls the setup time after that. It rises the low time later, and `rd_valid` is raised at that same edge. Chip select rises exactly setup+low+high edges after the block goes idle, or on the edge that accepts an end-of-burst. The bench samples every output at the falling clock edge. It counts the sampled cycles in each strobe phase and each idle stretch and compares those counts with these offsets. Each byte latched at a write rising edge is compared, in order, against a queue filled by bench functions when the request was issued.

// File: rtl/pbus_pkg.sv
// Package: shared widths and request/format codes for the parallel display bus master.
// Assumes an 8-bit bus and pixels of at most three bytes.
package pbus_pkg;
    localparam int BUS_W    = 8;
    localparam int PIX_BYTES = 3;
    localparam int PIX_W    = PIX_BYTES * BUS_W;

    localparam logic [2:0] KIND_CMD   = 3'd0;
    localparam logic [2:0] KIND_DATA  = 3'd1;
    localparam logic [2:0] KIND_PIXEL = 3'd2;
    localparam logic [2:0] KIND_READ  = 3'd3;

    localparam logic [1:0] FMT_565 = 2'd0;
    localparam logic [1:0] FMT_666 = 2'd1;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_LOW   = 2'd2,
        PH_HIGH  = 2'd3
    } phase_e;
endpackage

// File: rtl/pbus_pixel_pack.sv
// Module: pbus_pixel_pack
// Splits one pixel word into the bus bytes for the selected colour format.
// Byte 0 (bits BUS_W-1:0 of bytes_o) is sent first. Purely combinational.
// Assumes format codes 2 and 3 both mean three 8-bit components.
module pbus_pixel_pack
    import pbus_pkg::*;
(
    input  logic [1:0]                fmt_i,
    input  logic [PIX_W-1:0]          pix_i,
    output logic [PIX_BYTES*BUS_W-1:0] bytes_o,
    output logic [1:0]                count_o
);
    // Select byte order and padding per format.
    always_comb begin
        case (fmt_i)
            FMT_565: begin
                bytes_o = {{BUS_W{1'b0}}, pix_i[7:0], pix_i[15:8]};
                count_o = 2'd2;
            end
            FMT_666: begin
                bytes_o = {pix_i[5:0], 2'b00, pix_i[11:6], 2'b00, pix_i[17:12], 2'b00};
                count_o = 2'd3;
            end
            default: begin
                bytes_o = {pix_i[7:0], pix_i[15:8], pix_i[23:16]};
                count_o = 2'd3;
            end
        endcase
    end
endmodule

// File: rtl/pbus_strobe_engine.sv
// Module: pbus_strobe_engine
// Runs one bus byte cycle: setup, strobe low, strobe high, then back to idle.
// Drives data, command/data and driver enable from the start edge until the
// next start. Captures read data at the read strobe rising edge.
// Assumes timing inputs are stable while a cycle runs; a value of 0 counts as 1.
module pbus_strobe_engine
    import pbus_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             is_read_i,
    input  logic             dc_i,
    input  logic [BUS_W-1:0] byte_i,
    input  logic [CNT_W-1:0] setup_i,
    input  logic [CNT_W-1:0] low_i,
    input  logic [CNT_W-1:0] high_i,
    input  logic [BUS_W-1:0] d_in_i,
    output logic             idle_o,
    output logic             wr_n_o,
    output logic             rd_n_o,
    output logic             dc_o,
    output logic [BUS_W-1:0] d_out_o,
    output logic             d_oe_o,
    output logic             rd_valid_o,
    output logic [BUS_W-1:0] rd_data_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             rd_mode;

    // Turn a zero timing value into one cycle.
    function automatic logic [CNT_W-1:0] clamp1(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_ONE : v;
    endfunction

    assign idle_o = (phase == PH_IDLE);

    // Phase sequencer with per-phase down counter and bus register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            cnt        <= '0;
            rd_mode    <= 1'b0;
            wr_n_o     <= 1'b1;
            rd_n_o     <= 1'b1;
            dc_o       <= 1'b1;
            d_out_o    <= '0;
            d_oe_o     <= 1'b1;
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start_i) begin
                        rd_mode <= is_read_i;
                        d_oe_o  <= !is_read_i;
                        dc_o    <= is_read_i ? 1'b1 : dc_i;
                        if (!is_read_i) begin
                            d_out_o <= byte_i;
                        end
                        cnt   <= clamp1(setup_i);
                        phase <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (cnt == CNT_ONE) begin
                        cnt   <= clamp1(low_i);
                        phase <= PH_LOW;
                        if (rd_mode) begin
                            rd_n_o <= 1'b0;
                        end else begin
                            wr_n_o <= 1'b0;
                        end
                    end else begin
                        cnt <= cnt - CNT_ONE;
                    end
                end
                PH_LOW: begin
                    if (cnt == CNT_ONE) begin
                        cnt    <= clamp1(high_i);
                        phase  <= PH_HIGH;
                        wr_n_o <= 1'b1;
                        rd_n_o <= 1'b1;
                        if (rd_mode) begin
                            rd_valid_o <= 1'b1;
                            rd_data_o  <= d_in_i;
                        end
                    end else begin
                        cnt <= cnt - CNT_ONE;
                    end
                end
                default: begin
                    if (cnt == CNT_ONE) begin
                        phase  <= PH_IDLE;
                        d_oe_o <= 1'b1;
                    end else begin
                        cnt <= cnt - CNT_ONE;
                    end
                end
            endcase
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wr_n_o && !rd_n_o)); // R2

    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n_o && $past(!wr_n_o)) |-> ($stable(d_out_o) && $stable(dc_o))); // R3

    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> (!d_oe_o && dc_o)); // R9

    AST_RDV_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $rose(rd_n_o)); // R9
endmodule

// File: rtl/pbus_select_ctrl.sv
// Module: pbus_select_ctrl
// Owns chip select. Lowers it when a byte cycle starts and keeps it low
// through queued work. Raises it after gap_i idle cycles or on an end request.
// Assumes start_i and end_i never coincide.
module pbus_select_ctrl #(
    parameter int GAP_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             hold_i,
    input  logic             end_i,
    input  logic             idle_i,
    input  logic [GAP_W-1:0] gap_i,
    output logic             cs_n_o
);
    localparam logic [GAP_W-1:0] GAP_ONE = {{(GAP_W-1){1'b0}}, 1'b1};

    logic [GAP_W-1:0] idle_cnt;

    // Chip select level and idle-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_o   <= 1'b1;
            idle_cnt <= '0;
        end else if (start_i || hold_i) begin
            idle_cnt <= '0;
            if (start_i) begin
                cs_n_o <= 1'b0;
            end
        end else if (end_i) begin
            cs_n_o   <= 1'b1;
            idle_cnt <= '0;
        end else if (idle_i && !cs_n_o) begin
            if ((idle_cnt + GAP_ONE) >= gap_i) begin
                cs_n_o   <= 1'b1;
                idle_cnt <= '0;
            end else begin
                idle_cnt <= idle_cnt + GAP_ONE;
            end
        end
    end

    AST_CS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_i |-> !cs_n_o); // R2
endmodule

// File: rtl/pbus_display_master.sv
// Module: pbus_display_master
// Top of the 8080-style display bus master. Accepts one request at a time,
// expands it into one to three bus bytes and feeds them to the strobe engine.
// Chip select is handled by pbus_select_ctrl.
// Assumes timing and format inputs change only while chip select is high.
module pbus_display_master
    import pbus_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_kind,
    input  logic [23:0]      req_word,
    input  logic [1:0]       pix_fmt,
    input  logic [CNT_W-1:0] cfg_setup,
    input  logic [CNT_W-1:0] cfg_low,
    input  logic [CNT_W-1:0] cfg_high,
    output logic             bus_cs_n,
    output logic             bus_wr_n,
    output logic             bus_rd_n,
    output logic             bus_dc,
    output logic [7:0]       bus_d_out,
    output logic             bus_d_oe,
    input  logic [7:0]       bus_d_in,
    output logic             rd_valid,
    output logic [7:0]       rd_data
);
    localparam int GAP_W = CNT_W + 2;
    localparam int Q_W   = PIX_BYTES * BUS_W;

    logic [Q_W-1:0]   q_bytes;
    logic [1:0]       q_left;
    logic [1:0]       q_idx;
    logic             q_dc;
    logic             q_read;
    logic [Q_W-1:0]   pk_bytes;
    logic [1:0]       pk_count;
    logic [BUS_W-1:0] cur_byte;
    logic             eng_idle;
    logic             eng_start;
    logic             req_fire;
    logic             req_is_end;
    logic [GAP_W-1:0] gap_len;

    // Widen a timing value and turn zero into one.
    function automatic logic [GAP_W-1:0] widen1(input logic [CNT_W-1:0] v);
        return (v == '0) ? {{(GAP_W-1){1'b0}}, 1'b1} : {{(GAP_W-CNT_W){1'b0}}, v};
    endfunction

    assign req_fire   = req_valid && req_ready;
    assign req_is_end = req_kind[2];
    assign req_ready  = eng_idle && (q_left == 2'd0);
    assign eng_start  = eng_idle && (q_left != 2'd0);
    assign gap_len    = widen1(cfg_setup) + widen1(cfg_low) + widen1(cfg_high);

    pbus_pixel_pack u_pack (
        .fmt_i   (pix_fmt),
        .pix_i   (req_word),
        .bytes_o (pk_bytes),
        .count_o (pk_count)
    );

    // Pick the queued byte that goes out next.
    always_comb begin
        case (q_idx)
            2'd0:    cur_byte = q_bytes[BUS_W-1:0];
            2'd1:    cur_byte = q_bytes[2*BUS_W-1:BUS_W];
            default: cur_byte = q_bytes[3*BUS_W-1:2*BUS_W];
        endcase
    end

    // Load a request into the byte queue and step through it per byte start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_bytes <= '0;
            q_left  <= 2'd0;
            q_idx   <= 2'd0;
            q_dc    <= 1'b1;
            q_read  <= 1'b0;
        end else if (req_fire && !req_is_end) begin
            q_idx  <= 2'd0;
            q_dc   <= (req_kind != KIND_CMD);
            q_read <= (req_kind == KIND_READ);
            if (req_kind == KIND_PIXEL) begin
                q_bytes <= pk_bytes;
                q_left  <= pk_count;
            end else begin
                q_bytes <= {{(Q_W-BUS_W){1'b0}}, req_word[BUS_W-1:0]};
                q_left  <= 2'd1;
            end
        end else if (eng_start) begin
            q_left <= q_left - 2'd1;
            q_idx  <= q_idx + 2'd1;
        end
    end

    pbus_strobe_engine #(
        .CNT_W (CNT_W)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (eng_start),
        .is_read_i  (q_read),
        .dc_i       (q_dc),
        .byte_i     (cur_byte),
        .setup_i    (cfg_setup),
        .low_i      (cfg_low),
        .high_i     (cfg_high),
        .d_in_i     (bus_d_in),
        .idle_o     (eng_idle),
        .wr_n_o     (bus_wr_n),
        .rd_n_o     (bus_rd_n),
        .dc_o       (bus_dc),
        .d_out_o    (bus_d_out),
        .d_oe_o     (bus_d_oe),
        .rd_valid_o (rd_valid),
        .rd_data_o  (rd_data)
    );

    pbus_select_ctrl #(
        .GAP_W (GAP_W)
    ) u_select (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (eng_start),
        .hold_i  (req_fire && !req_is_end),
        .end_i   (req_fire && req_is_end),
        .idle_i  (eng_idle),
        .gap_i   (gap_len),
        .cs_n_o  (bus_cs_n)
    );

    AST_NO_STROBE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_wr_n && bus_rd_n)); // R10

    AST_CS_BEFORE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_wr_n) |-> $past(!bus_cs_n)); // R2

    AST_END_RAISES_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fire && req_is_end) |=> bus_cs_n); // R12

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fire && !req_is_end) |=> !req_ready); // R10
endmodule

// File: tb/pbus_display_master_tb.sv
// Bench: directed corner cases plus seeded random requests for the display bus
// master. A falling-edge monitor models the display and checks every strobe.
module pbus_display_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = 3'd0;
    logic [23:0] req_word = '0;
    logic [1:0]  pix_fmt = 2'd0;
    logic [7:0]  cfg_setup = 8'd2;
    logic [7:0]  cfg_low = 8'd3;
    logic [7:0]  cfg_high = 8'd1;
    logic        bus_cs_n, bus_wr_n, bus_rd_n, bus_dc, bus_d_oe;
    logic [7:0]  bus_d_out;
    logic [7:0]  bus_d_in;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [7:0]  disp_val = 8'h00;

    int nchk = 0;
    int nbad = 0;
    bit mon_en = 1'b0;
    bit end_flag = 1'b0;
    bit finished = 1'b0;
    logic [8:0] exp_q[$];

    always #2.5 clk = ~clk;

    assign bus_d_in = bus_rd_n ? 8'h00 : disp_val;

    pbus_display_master dut_i (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_kind (req_kind), .req_word (req_word), .pix_fmt (pix_fmt),
        .cfg_setup (cfg_setup), .cfg_low (cfg_low), .cfg_high (cfg_high),
        .bus_cs_n (bus_cs_n), .bus_wr_n (bus_wr_n), .bus_rd_n (bus_rd_n),
        .bus_dc (bus_dc), .bus_d_out (bus_d_out), .bus_d_oe (bus_d_oe),
        .bus_d_in (bus_d_in), .rd_valid (rd_valid), .rd_data (rd_data)
    );

    function automatic int cl(input logic [7:0] v);
        return (v == 8'd0) ? 1 : int'(v);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected bytes of one pixel per format (R6, R7, R8).
    task automatic push_pixel(input logic [1:0] fmt, input logic [23:0] w);
        if (fmt == 2'd0) begin
            exp_q.push_back({1'b1, w[15:8]});
            exp_q.push_back({1'b1, w[7:0]});
        end else if (fmt == 2'd1) begin
            exp_q.push_back({1'b1, w[17:12], 2'b00});
            exp_q.push_back({1'b1, w[11:6], 2'b00});
            exp_q.push_back({1'b1, w[5:0], 2'b00});
        end else begin
            exp_q.push_back({1'b1, w[23:16]});
            exp_q.push_back({1'b1, w[15:8]});
            exp_q.push_back({1'b1, w[7:0]});
        end
    endtask

    task automatic send(input logic [2:0] kind, input logic [23:0] w);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        case (kind)
            3'd0: exp_q.push_back({1'b0, w[7:0]});
            3'd1: exp_q.push_back({1'b1, w[7:0]});
            3'd2: push_pixel(pix_fmt, w);
            3'd3: disp_val = w[7:0];
            default: end_flag = 1'b1;
        endcase
        req_kind  = kind;
        req_word  = w;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (kind[2]) begin
            chk(bus_cs_n == 1'b1 && bus_wr_n && bus_rd_n, "R12 cs after end", int'(bus_cs_n), 1);
        end else begin
            chk(req_ready == 1'b0, "R10 ready after accept", int'(req_ready), 0);
        end
    endtask

    task automatic set_cfg(input logic [7:0] s, input logic [7:0] l, input logic [7:0] h);
        send(3'd4, 24'd0);
        cfg_setup = s;
        cfg_low   = l;
        cfg_high  = h;
    endtask

    // Falling-edge monitor: strobe widths, setup, byte order, reads, chip select.
    logic       p_wr = 1'b1, p_rd = 1'b1, p_cs = 1'b1, p_dc = 1'b1, p_oe = 1'b1;
    logic [7:0] p_d = '0;
    int stab = 0, lowc = 0, hic = 0, rdl = 0, idc = 0;
    bit chain = 1'b0;
    always @(negedge clk) begin
        if (mon_en) begin
            logic [8:0] e;
            int cs_v, cl_v, ch_v;
            cs_v = cl(cfg_setup); cl_v = cl(cfg_low); ch_v = cl(cfg_high);
            if (bus_d_out != p_d || bus_dc != p_dc || bus_d_oe != p_oe) stab = 0;
            else stab++;
            chk(!(!bus_wr_n && !bus_rd_n), "R2 both strobes low", 0, 1);
            if (req_ready) begin
                chain = 1'b0;
                chk(bus_wr_n && bus_rd_n, "R10 strobe while ready", 0, 1);
            end
            if (!bus_wr_n && p_wr) begin
                chk(stab >= cs_v, "R3 setup before fall", stab, cs_v);
                chk(p_cs == 1'b0, "R2 cs before fall", int'(p_cs), 0);
                if (chain) chk(hic == ch_v + 1 + cs_v, "R5 high gap", hic, ch_v + 1 + cs_v);
            end
            if (!bus_wr_n) begin
                lowc++;
                chk(!bus_cs_n && bus_d_oe, "R2 cs/oe during write", int'(bus_cs_n), 0);
            end
            if (bus_wr_n && !p_wr) begin
                chk(lowc == cl_v, "R5 low width", lowc, cl_v);
                chk(stab >= cs_v + cl_v, "R3 data held to rise", stab, cs_v + cl_v);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected byte", int'({p_dc, p_d}), 0);
                end else begin
                    e = exp_q.pop_front();
                    chk({p_dc, p_d} == e, "R4/R6/R7/R8 byte", int'({p_dc, p_d}), int'(e));
                end
                lowc = 0; hic = 1; chain = 1'b1;
            end else if (bus_wr_n) begin
                hic++;
            end
            if (!bus_rd_n) begin
                rdl++;
                chk(!bus_d_oe && bus_dc && !bus_cs_n, "R9 read bus state", int'({bus_d_oe, bus_dc}), 1);
            end
            if (bus_rd_n && !p_rd) begin
                chk(rdl == cl_v, "R9 read low width", rdl, cl_v);
                chk(rd_valid && rd_data == disp_val, "R9 read data", int'(rd_data), int'(disp_val));
                rdl = 0;
            end else if (rd_valid) begin
                chk(1'b0, "R9 stray valid", 1, 0);
            end
            if (!bus_cs_n && req_ready) idc++;
            else if (!req_ready) idc = 0;
            if (bus_cs_n && !p_cs) begin
                if (!end_flag) chk(idc == cs_v + cl_v + ch_v, "R11 idle gap", idc, cs_v + cl_v + ch_v);
                idc = 0;
            end
            if (bus_cs_n) begin
                end_flag = 1'b0;
                idc = 0;
            end
            p_wr = bus_wr_n; p_rd = bus_rd_n; p_cs = bus_cs_n;
            p_d = bus_d_out; p_dc = bus_dc; p_oe = bus_d_oe;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h00C0FFEE);
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_cs_n && bus_wr_n && bus_rd_n && bus_d_oe && !rd_valid && req_ready,
            "R1 reset state", int'({bus_cs_n, bus_wr_n, bus_rd_n, bus_d_oe, rd_valid, req_ready}), 6'b111101);
        mon_en = 1'b1;

        // Directed: command, data, each pixel format, read, end.
        send(3'd0, 24'h00002A);
        send(3'd1, 24'h000000);
        pix_fmt = 2'd0; send(3'd2, 24'h00F81F);
        pix_fmt = 2'd1; send(3'd2, {6'd0, 6'h3F, 6'h15, 6'h01});
        pix_fmt = 2'd2; send(3'd2, 24'h123456);
        pix_fmt = 2'd3; send(3'd2, 24'hABCDEF);
        send(3'd3, 24'h00005A);
        send(3'd1, 24'h0000FF);
        repeat (12) @(negedge clk);
        send(3'd5, 24'd0);
        set_cfg(8'd0, 8'd0, 8'd0);
        send(3'd0, 24'h00002C);
        pix_fmt = 2'd0; send(3'd2, 24'h00A5C3);
        send(3'd3, 24'h0000C3);
        set_cfg(8'd9, 8'd12, 8'd7);
        pix_fmt = 2'd1; send(3'd2, 24'hFFFFFF);

        // Seeded random mix of requests, formats and timing.
        for (int i = 0; i < 250; i++) begin
            int k;
            if (($urandom % 40) == 0)
                set_cfg(8'($urandom_range(0, 6)), 8'($urandom_range(0, 6)), 8'($urandom_range(0, 6)));
            pix_fmt = 2'($urandom_range(0, 3));
            k = $urandom_range(0, 9);
            if (k < 2) send(3'd0, 24'($urandom));
            else if (k < 4) send(3'd1, 24'($urandom));
            else if (k < 8) send(3'd2, 24'($urandom));
            else if (k < 9) send(3'd3, 24'($urandom));
            else send(3'($urandom_range(4, 7)), 24'd0);
            repeat ($urandom_range(0, 24)) @(negedge clk);
        end

        while (!req_ready) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, "R6/R7/R8 all bytes sent", exp_q.size(), 0);
        chk(bus_cs_n == 1'b1, "R11 cs released when idle", int'(bus_cs_n), 1);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end
endmodule